// File: doc/BRIEF.md
# Pulse-Spreading PWM Generator

This block is a single PWM channel whose frame lasts two to the power of a selectable resolution, from 7 to 12 bits, in clock cycles. A duty count sets how many cycles of each frame the output is active. In the plain mode those active cycles form one pulse at the start of the frame. Two spreading modes cut the frame into 4 or 32 equal slots and share the active time among them. This raises the output's fundamental frequency, so a smaller external filter can be used, and it keeps the full duty resolution.

Duty, resolution, mode and polarity are taken into shadow storage only when a new frame begins. A channel that is running therefore always completes the frame it started with one consistent set of settings. When the enable is low, the output rests at its inactive level and the frame counter waits at the start of a frame.

Top module: `pwm_spread`

## Requirements
- R1: `res_bits` is read as an unsigned bit count. Values below 7 act as 7 and values above 12 act as 12. The frame lasts 2^N cycles for the effective resolution N.
- R2: With both spread selects low, the output is active for the first min(duty, 2^N) cycles of each frame and inactive for the rest.
- R3: With `spread4`=1, the frame is cut into 4 slots of 2^N/4 cycles. Slot k (k=0..3) is active at its start for duty/4 cycles, plus one more cycle when k < duty mod 4.
- R4: With `spread32`=1, `spread4`=0 and N=12, the frame is cut into 32 slots of 128 cycles. Slot k is active at its start for duty/32 cycles, plus one more cycle when k < duty mod 32.
- R5: `spread32`=1 at a resolution other than 12 with `spread4`=0 gives the plain mode. Both selects high gives 4-slot spreading at any resolution.
- R6: In every mode, a duty of 0 keeps the output inactive for the whole frame, and a duty of 2^N or more keeps it active for the whole frame.
- R7: With `invert`=1 the output is the complement of the non-inverted waveform, so the inactive level is high.
- R8: Inputs are sampled only on the edge that starts a frame. A change made partway through a frame takes effect from the next frame, and the current frame finishes unchanged.
- R9: While `enable` is sampled low, the counter returns to the start of a frame. From the next cycle the output equals the `invert` value sampled on that edge. The first edge that samples `enable` high loads the settings, and frame cycle 0 is output in the cycle that follows.
- R10: After reset the channel is idle and `pwm_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Channel run enable |
| invert | input | 1 | Output polarity inversion |
| spread4 | input | 1 | Selects 4-slot spreading |
| spread32 | input | 1 | Selects 32-slot spreading (12-bit only) |
| res_bits | input | 4 | Resolution in bits, clamped to 7..12 |
| duty | input | 12 | Active cycles per frame |
| pwm_out | output | 1 | PWM output |

## Verification
A wrong frame counter or wrong shadow settings show at `pwm_out` within one frame. An off-by-one in a slot's share moves a single edge by one cycle in that slot. A bad wrap point changes the spacing between the edges of the next frame. Comparing every output cycle of whole frames against a cycle-accurate model catches both kinds of fault at the first cycle that differs. The mid-frame change case shows a premature latch within the current frame rather than a frame later.

// File: rtl/pwm_spread_pkg.sv
package pwm_spread_pkg;
  localparam int CNT_W   = 12;  // widest frame counter
  localparam int RES_W   = 4;   // resolution input width
  localparam int MIN_RES = 7;
  localparam int MAX_RES = 12;
  localparam int SHIFT_W = 3;   // log2 of slot count
  localparam int LOG_S4  = 2;
  localparam int LOG_S32 = 5;

  typedef struct packed {
    logic [RES_W-1:0]   res;    // effective resolution
    logic [CNT_W:0]     duty;   // saturated to frame length
    logic [SHIFT_W-1:0] shift;  // log2 of slot count
    logic               inv;
  } cfg_t;
endpackage

// File: rtl/pwm_cfg_decode.sv
module pwm_cfg_decode
  import pwm_spread_pkg::*;
(
  input  logic [RES_W-1:0] res_in,
  input  logic [CNT_W-1:0] duty_in,
  input  logic             sel4,
  input  logic             sel32,
  input  logic             inv_in,
  output cfg_t             cfg
);
  localparam logic [RES_W-1:0] RES_LO = RES_W'(MIN_RES);
  localparam logic [RES_W-1:0] RES_HI = RES_W'(MAX_RES);

  logic [RES_W-1:0] res_eff;
  logic [CNT_W:0]   frame_len;
  logic [CNT_W:0]   duty_x;

  always_comb begin
    if (res_in < RES_LO)      res_eff = RES_LO;
    else if (res_in > RES_HI) res_eff = RES_HI;
    else                      res_eff = res_in;
  end

  assign frame_len = (CNT_W+1)'(1) << res_eff;
  assign duty_x    = {1'b0, duty_in};

  always_comb begin
    cfg.res  = res_eff;
    cfg.inv  = inv_in;
    cfg.duty = (duty_x >= frame_len) ? frame_len : duty_x;
    if (sel4)
      cfg.shift = SHIFT_W'(LOG_S4);
    else if (sel32 && res_eff == RES_HI)
      cfg.shift = SHIFT_W'(LOG_S32);
    else
      cfg.shift = '0;
  end
endmodule

// File: rtl/pwm_frame_ctr.sv
module pwm_frame_ctr
  import pwm_spread_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  cfg_t             cfg_in,
  output logic             run_q,
  output logic [CNT_W-1:0] cnt_q,
  output cfg_t             cfg_q
);
  logic             run_d;
  logic [CNT_W-1:0] cnt_d;
  cfg_t             cfg_d;
  logic [CNT_W:0]   last_x;
  logic             at_last;
  logic             load_en;

  assign last_x  = ((CNT_W+1)'(1) << cfg_q.res) - (CNT_W+1)'(1);
  assign at_last = ({1'b0, cnt_q} == last_x);
  assign load_en = !enable || !run_q || at_last;

  always_comb begin
    run_d = enable;
    cnt_d = cnt_q;
    if (!enable || !run_q)
      cnt_d = '0;
    else if (at_last)
      cnt_d = '0;
    else
      cnt_d = cnt_q + CNT_W'(1);
    cfg_d = load_en ? cfg_in : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      cfg_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
      cfg_q <= cfg_d;
    end
  end
endmodule

// File: rtl/pwm_slot_cmp.sv
module pwm_slot_cmp
  import pwm_spread_pkg::*;
(
  input  logic [CNT_W-1:0] cnt,
  input  cfg_t             cfg,
  output logic             active
);
  localparam int XW = CNT_W + 1;

  logic [RES_W-1:0] seg_bits;
  logic [XW-1:0]    cnt_x, slot_idx, pos, seg_mask;
  logic [XW-1:0]    base, rem, rem_mask, share;

  always_comb begin
    seg_bits = cfg.res - RES_W'(cfg.shift);
    cnt_x    = {1'b0, cnt};
    seg_mask = (XW'(1) << seg_bits) - XW'(1);
    slot_idx = cnt_x >> seg_bits;
    pos      = cnt_x & seg_mask;
    rem_mask = (XW'(1) << cfg.shift) - XW'(1);
    base     = cfg.duty >> cfg.shift;
    rem      = cfg.duty & rem_mask;
    share    = base + XW'(slot_idx < rem);
    active   = pos < share;
  end
endmodule

// File: rtl/pwm_spread.sv
module pwm_spread
  import pwm_spread_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             invert,
  input  logic             spread4,
  input  logic             spread32,
  input  logic [RES_W-1:0] res_bits,
  input  logic [CNT_W-1:0] duty,
  output logic             pwm_out
);
  cfg_t             cfg_live;
  cfg_t             cfg_q;
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic             active;

  pwm_cfg_decode u_dec (
    .res_in (res_bits),
    .duty_in(duty),
    .sel4   (spread4),
    .sel32  (spread32),
    .inv_in (invert),
    .cfg    (cfg_live)
  );

  pwm_frame_ctr u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .enable(enable),
    .cfg_in(cfg_live),
    .run_q (run_q),
    .cnt_q (cnt_q),
    .cfg_q (cfg_q)
  );

  pwm_slot_cmp u_cmp (
    .cnt   (cnt_q),
    .cfg   (cfg_q),
    .active(active)
  );

  assign pwm_out = run_q ? (active ^ cfg_q.inv) : cfg_q.inv;
endmodule

// File: rtl/pwm_spread_chk.sv
module pwm_spread_chk
  import pwm_spread_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             invert,
  input logic             pwm_out,
  input logic             run_q,
  input logic [CNT_W-1:0] cnt_q,
  input cfg_t             cfg_q
);
  logic [CNT_W:0] frame_n;
  assign frame_n = (CNT_W+1)'(1) << cfg_q.res;

  // R1
  cnt_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> ({1'b0, cnt_q} < frame_n));

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && enable && ({1'b0, cnt_q} != frame_n - 1)) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && enable && ({1'b0, cnt_q} != frame_n - 1)) |=> $stable(cfg_q));

  // R9
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (pwm_out == $past(invert)));

  // R9
  start_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (cnt_q == '0));

  // R6
  zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cfg_q.duty == '0) |-> (pwm_out == cfg_q.inv));

  // R6
  full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cfg_q.duty == frame_n) |-> (pwm_out == !cfg_q.inv));
endmodule

bind pwm_spread pwm_spread_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .enable (enable),
  .invert (invert),
  .pwm_out(pwm_out),
  .run_q  (run_q),
  .cnt_q  (cnt_q),
  .cfg_q  (cfg_q)
);

// File: tb/tb_pwm_spread.sv
module tb_pwm_spread;
  logic        clk;
  logic        rst_n;
  logic        enable;
  logic        invert;
  logic        spread4;
  logic        spread32;
  logic [3:0]  res_bits;
  logic [11:0] duty;
  logic        pwm_out;

  int checks   = 0;
  int failures = 0;
  bit mon_on   = 0;

  typedef struct {
    logic  val;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  pwm_spread dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .invert(invert),
    .spread4(spread4), .spread32(spread32), .res_bits(res_bits),
    .duty(duty), .pwm_out(pwm_out)
  );

  initial clk = 0;
  always #2 clk = ~clk;   // 250 MHz

  function automatic int eff_res(int r);
    if (r < 7) return 7;
    if (r > 12) return 12;
    return r;
  endfunction

  // model of the requirements: slot count, slot length, per-slot share
  function automatic logic model_bit(int r_in, int d, bit s4, bit s32, bit inv, int c);
    int r      = eff_res(r_in);
    int frame  = 1 << r;
    int slots  = s4 ? 4 : ((s32 && r == 12) ? 32 : 1);
    int len    = frame / slots;
    int k      = c / len;
    int p      = c % len;
    int dd     = (d >= frame) ? frame : d;
    int h      = dd / slots + ((k < dd % slots) ? 1 : 0);
    return (p < h) ? !inv : inv;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per cycle
  always @(negedge clk) begin
    if (mon_on && sb_q.size() != 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.tag, pwm_out, e.val);
    end
  end

  task automatic push_frame(int r, int d, bit s4, bit s32, bit inv, string tag);
    int frame = 1 << eff_res(r);
    for (int c = 0; c < frame; c++) begin
      exp_t e;
      e.val = model_bit(r, d, s4, s32, inv, c);
      e.tag = tag;
      sb_q.push_back(e);
    end
  endtask

  task automatic setup(int r, int d, bit s4, bit s32, bit inv);
    @(negedge clk);
    enable = 0; res_bits = 4'(r); duty = 12'(d);
    spread4 = s4; spread32 = s32; invert = inv;
    repeat (2) @(negedge clk);
  endtask

  task automatic start_and_drain();
    enable = 1;
    @(posedge clk);
    mon_on = 1;
    wait (sb_q.size() == 0);
    @(negedge clk);
    mon_on = 0;
    enable = 0;
    @(posedge clk);
    @(negedge clk);
    // R9: idle level equals invert
    check("R9 idle level", pwm_out, invert);
  endtask

  task automatic run_case(int r, int d, bit s4, bit s32, bit inv, string tag);
    setup(r, d, s4, s32, inv);
    push_frame(r, d, s4, s32, inv, tag);
    start_and_drain();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0; enable = 0; invert = 0; spread4 = 0; spread32 = 0;
    res_bits = 4'd9; duty = '0;
    repeat (3) @(negedge clk);
    // R10: idle and low in reset
    check("R10 reset level", pwm_out, 1'b0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R10 idle after reset", pwm_out, 1'b0);

    run_case(9, 128, 0, 0, 0, "R2 normal 9b d128");
    run_case(9, 127, 1, 0, 0, "R3 4-slot 9b d127");
    run_case(7, 5,   1, 0, 0, "R3 4-slot 7b d5");
    run_case(12, 1000, 0, 1, 0, "R4 32-slot 12b d1000");
    run_case(12, 45, 0, 1, 0, "R4 32-slot 12b d45");
    run_case(10, 300, 0, 1, 0, "R5 32-slot at 10b falls to normal");
    run_case(12, 77, 1, 1, 0, "R5 both selects give 4-slot");
    run_case(8, 0, 1, 0, 0, "R6 zero duty 4-slot");
    run_case(7, 200, 0, 0, 1, "R6 saturated duty inverted");
    run_case(8, 50, 0, 0, 1, "R7 inverted normal");
    run_case(3, 20, 0, 0, 0, "R1 res clamp low");
    run_case(15, 2500, 1, 0, 0, "R1 res clamp high");

    // R8: mid-frame change applies from the next frame
    setup(8, 40, 0, 0, 0);
    push_frame(8, 40, 0, 0, 0, "R8 first frame keeps old");
    push_frame(9, 100, 1, 0, 0, "R8 second frame new");
    enable = 1;
    @(posedge clk);
    mon_on = 1;
    repeat (10) @(negedge clk);
    res_bits = 4'd9; duty = 12'd100; spread4 = 1;
    wait (sb_q.size() == 0);
    @(negedge clk);
    mon_on = 0;
    enable = 0;
    @(posedge clk);
    @(negedge clk);
    check("R9 idle after R8", pwm_out, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule